// File: doc/BRIEF.md
# Rolling-Shutter Pixel Address Sequencer

This block drives the row and column select lines of an integrating image sensor array. One scan counter walks the array pixel by pixel, with the column index moving fastest. Two separate address decoders turn that count into two selections in the same clock slot. One selection marks the pixel being read out. The other marks the pixel being reset, which lies a programmable number of slots ahead of the read position. There is no separate reset sweep and read sweep. Every pixel is therefore read the same number of slots after its reset, and that number is the integration time.

The integration offset comes in as a plain input value. The block clamps it to a legal range and commits it only when the scan wraps back to the first pixel. A whole frame therefore always runs with one offset. After a system reset, read selection is held off until enough slots have passed that the pixel under read has really been reset. A pixel-valid strobe marks the read selections that are good. A frame-start flag marks the first slot of each new frame.

Top module: `pix_scan_seq`

## Requirements
- R1: While `en_i` is high, the read address advances by one per clock. It wraps from ROWS*COLS-1 to 0. Read address `a` selects row `a / COLS` (bit index in `rd_row_o`) and column `a % COLS` (bit index in `rd_col_o`).
- R2: In the same cycle, the reset selection marks address `(a + k) mod (ROWS*COLS)`, where `k` is the active offset. It uses the same row and column bit mapping as the read selection.
- R3: While `en_i` is high, `rst_row_o` and `rst_col_o` each have exactly one bit set. While `pix_valid_o` is high, `rd_row_o` and `rd_col_o` each have exactly one bit set.
- R4: Whenever `pix_valid_o` is high, the reset pixel and the read pixel are different.
- R5: The offset input is clamped. A value of 0 acts as 1, and any value of ROWS*COLS or more acts as ROWS*COLS-1.
- R6: Before the first advance after reset, the live (clamped) offset input is used. It is latched on that first advance. After that, the active offset changes only on the advance that wraps the scan to address 0.
- R7: After reset, `pix_valid_o` stays low until the number of advances since reset is at least the active offset. While `pix_valid_o` is low, `rd_row_o` and `rd_col_o` are all zeros.
- R8: While `en_i` is low, the scan counter holds, all four select vectors are zero and `pix_valid_o` is low.
- R9: `frame_start_o` is high for exactly one clock, the cycle after an advance from address ROWS*COLS-1 to 0. It is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Scan enable; low freezes the scan and blanks all selects |
| offset_i | input | $clog2(ROWS*COLS) | Requested integration time in pixel slots |
| rst_row_o | output | ROWS | One-hot row select of the pixel being reset |
| rst_col_o | output | COLS | One-hot column select of the pixel being reset |
| rd_row_o | output | ROWS | One-hot row select of the pixel being read |
| rd_col_o | output | COLS | One-hot column select of the pixel being read |
| pix_valid_o | output | 1 | Read selection carries a properly integrated pixel |
| frame_start_o | output | 1 | One-clock pulse on the first slot of a new frame |

## Verification
The assertions check on every cycle that the selections are one-hot and that the reset pixel never coincides with the read pixel. They also check that the active offset stays in range and stays fixed within a frame, that the counter steps by one or holds while disabled, and that frame start only appears at address 0. Only the bench's reference model can show the exact distance between the reset and read pixels and the clamping of the out-of-range offsets. The same holds for the slot where a mid-frame offset change finally takes effect and the exact length of the start-up valid delay after a repeated reset.

// File: rtl/pix_seq_pkg.sv
package pix_seq_pkg;
  function automatic int unsigned idx_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pix_scan_counter.sv
module pix_scan_counter #(
  parameter int unsigned NPIX = 24,
  parameter int unsigned AW   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          wrap_o,
  output logic          frame_start_o
);
  localparam logic [AW-1:0] LAST = AW'(NPIX - 1);

  logic [AW-1:0] addr_q;
  logic          fs_q;

  assign wrap_o        = adv_i && (addr_q == LAST);
  assign addr_o        = addr_q;
  assign frame_start_o = fs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      fs_q   <= 1'b0;
    end else begin
      fs_q <= wrap_o;
      if (adv_i) addr_q <= (addr_q == LAST) ? '0 : addr_q + AW'(1);
    end
  end

  AST_SCAN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && addr_q != LAST) |=> addr_q == $past(addr_q) + AW'(1)); // R1
  AST_SCAN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && addr_q == LAST) |=> addr_q == '0); // R1
  AST_SCAN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(addr_q)); // R8
  AST_FS_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |-> addr_q == '0); // R9
  AST_FS_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |=> !fs_q); // R9
endmodule

// File: rtl/pix_offset_ctrl.sv
module pix_offset_ctrl #(
  parameter int unsigned NPIX = 24,
  parameter int unsigned AW   = 5,
  parameter int unsigned CW   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          wrap_i,
  input  logic [AW-1:0] offset_i,
  output logic [AW-1:0] eff_off_o,
  output logic          warm_o
);
  localparam logic [AW-1:0] OFF_MAX = AW'(NPIX - 1);
  localparam logic [CW-1:0] CNT_SAT = CW'(NPIX);

  logic [AW-1:0] req_off;
  logic [AW-1:0] off_q;
  logic          started_q;
  logic [CW-1:0] cnt_q;
  logic          load;

  always_comb begin
    if (offset_i == '0)          req_off = AW'(1);
    else if (offset_i > OFF_MAX) req_off = OFF_MAX;
    else                         req_off = offset_i;
  end

  assign eff_off_o = started_q ? off_q : req_off;
  assign load      = (adv_i && !started_q) || wrap_i;
  assign warm_o    = cnt_q >= CW'(eff_off_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q     <= AW'(1);
      started_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (load) off_q <= req_off;
      if (adv_i) started_q <= 1'b1;
      if (adv_i && cnt_q < CNT_SAT) cnt_q <= cnt_q + CW'(1);
    end
  end

  AST_OFF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_off_o != '0 && eff_off_o <= OFF_MAX); // R5
  AST_OFF_FRAME_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !wrap_i) |=> $stable(eff_off_o)); // R6
  AST_WARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_o && started_q && !wrap_i) |=> warm_o); // R7
endmodule

// File: rtl/pix_addr_decoder.sv
module pix_addr_decoder #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 6,
  parameter int unsigned AW   = 5
) (
  input  logic            en_i,
  input  logic [AW-1:0]   addr_i,
  output logic [ROWS-1:0] row_o,
  output logic [COLS-1:0] col_o
);
  int unsigned row_idx, col_idx;

  always_comb begin
    row_idx = 32'(addr_i) / COLS;
    col_idx = 32'(addr_i) % COLS;
    for (int unsigned r = 0; r < ROWS; r++) row_o[r] = en_i && (row_idx == r);
    for (int unsigned c = 0; c < COLS; c++) col_o[c] = en_i && (col_idx == c);
  end
endmodule

// File: rtl/pix_scan_seq.sv
module pix_scan_seq
  import pix_seq_pkg::*;
#(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 6,
  localparam int unsigned NPIX = ROWS * COLS,
  localparam int unsigned AW   = idx_w(NPIX),
  localparam int unsigned CW   = idx_w(NPIX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [AW-1:0]   offset_i,
  output logic [ROWS-1:0] rst_row_o,
  output logic [COLS-1:0] rst_col_o,
  output logic [ROWS-1:0] rd_row_o,
  output logic [COLS-1:0] rd_col_o,
  output logic            pix_valid_o,
  output logic            frame_start_o
);
  logic [AW-1:0] rd_addr, rst_addr, eff_off;
  logic [AW:0]   addr_sum;
  logic          wrap, warm;

  pix_scan_counter #(.NPIX(NPIX), .AW(AW)) i_cnt (
    .clk_i, .rst_ni, .adv_i(en_i), .addr_o(rd_addr),
    .wrap_o(wrap), .frame_start_o
  );

  pix_offset_ctrl #(.NPIX(NPIX), .AW(AW), .CW(CW)) i_off (
    .clk_i, .rst_ni, .adv_i(en_i), .wrap_i(wrap), .offset_i,
    .eff_off_o(eff_off), .warm_o(warm)
  );

  // reset pointer runs ahead of read pointer, modulo array size
  always_comb begin
    addr_sum = {1'b0, rd_addr} + {1'b0, eff_off};
    if (addr_sum >= (AW+1)'(NPIX)) addr_sum = addr_sum - (AW+1)'(NPIX);
    rst_addr = addr_sum[AW-1:0];
  end

  assign pix_valid_o = en_i && warm;

  pix_addr_decoder #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) i_dec_rst (
    .en_i(en_i), .addr_i(rst_addr), .row_o(rst_row_o), .col_o(rst_col_o)
  );

  pix_addr_decoder #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) i_dec_rd (
    .en_i(pix_valid_o), .addr_i(rd_addr), .row_o(rd_row_o), .col_o(rd_col_o)
  );

  AST_RST_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> ($countones(rst_row_o) == 1 && $countones(rst_col_o) == 1)); // R3
  AST_RD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> ($countones(rd_row_o) == 1 && $countones(rd_col_o) == 1)); // R3
  AST_DISTINCT_PIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> !(rst_row_o == rd_row_o && rst_col_o == rd_col_o)); // R4
  AST_RD_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> (rd_row_o == '0 && rd_col_o == '0)); // R7
  AST_IDLE_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (rst_row_o == '0 && rst_col_o == '0 && !pix_valid_o)); // R8
endmodule

// File: tb/test_pix_scan_seq.sv
`timescale 1ns/1ps
module test_pix_scan_seq;
  localparam int ROWS = 4;
  localparam int COLS = 6;
  localparam int NPIX = ROWS * COLS;
  localparam int AW   = $clog2(NPIX);

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            en_i = 1'b0;
  logic [AW-1:0]   offset_i = AW'(5);
  logic [ROWS-1:0] rst_row_o, rd_row_o;
  logic [COLS-1:0] rst_col_o, rd_col_o;
  logic            pix_valid_o, frame_start_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string scen = "reset";

  // reference model state
  int m_rd = 0, m_off = 1, m_cnt = 0, m_fs = 0;
  bit m_started = 0;

  always #2.5 clk = ~clk;

  pix_scan_seq #(.ROWS(ROWS), .COLS(COLS)) i_pix_scan_seq (
    .clk_i(clk), .rst_ni, .en_i, .offset_i,
    .rst_row_o, .rst_col_o, .rd_row_o, .rd_col_o, .pix_valid_o, .frame_start_o
  );

  function automatic int clamp_off(int v);
    if (v == 0) return 1;
    if (v > NPIX - 1) return NPIX - 1;
    return v;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, scen, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_rd = 0; m_off = 1; m_cnt = 0; m_fs = 0; m_started = 0;
    end else if (en_i) begin
      if (!m_started) m_off = clamp_off(int'(offset_i));
      m_started = 1;
      m_fs = (m_rd == NPIX - 1);
      if (m_rd == NPIX - 1) begin
        m_off = clamp_off(int'(offset_i));
        m_rd = 0;
      end else m_rd++;
      if (m_cnt < NPIX) m_cnt++;
    end else m_fs = 0;
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      int eff, ra;
      bit val;
      logic [ROWS-1:0] e_rr, e_dr;
      logic [COLS-1:0] e_rc, e_dc;
      eff = m_started ? m_off : clamp_off(int'(offset_i));
      ra  = (m_rd + eff) % NPIX;
      val = en_i && (m_cnt >= eff);
      e_rr = en_i ? ROWS'(1) << (ra / COLS) : '0;
      e_rc = en_i ? COLS'(1) << (ra % COLS) : '0;
      e_dr = val ? ROWS'(1) << (m_rd / COLS) : '0;
      e_dc = val ? COLS'(1) << (m_rd % COLS) : '0;
      chk(rst_row_o == e_rr, "R2 reset row", rst_row_o, e_rr);
      chk(rst_col_o == e_rc, "R2 reset col", rst_col_o, e_rc);
      chk(rd_row_o == e_dr, "R1 read row", rd_row_o, e_dr);
      chk(rd_col_o == e_dc, "R1 read col", rd_col_o, e_dc);
      chk(pix_valid_o == val, "R7 valid", pix_valid_o, val);
      chk(frame_start_o == 1'(m_fs), "R9 frame start", frame_start_o, m_fs);
      if (en_i)
        chk($countones(rst_row_o) == 1 && $countones(rst_col_o) == 1,
            "R3 reset one-hot", {rst_row_o, rst_col_o}, 0);
      if (pix_valid_o)
        chk(!(rst_row_o == rd_row_o && rst_col_o == rd_col_o),
            "R4 distinct pixels", {rd_row_o, rd_col_o}, 0);
      if (!en_i)
        chk(rst_row_o == '0 && rst_col_o == '0 && rd_row_o == '0 && rd_col_o == '0 && !pix_valid_o,
            "R8 idle blank", {rst_row_o, rst_col_o, rd_row_o, rd_col_o}, 0);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    scen = "R8 idle after reset";
    step(4);
    scen = "R1 R2 R7 R9 two frames offset 5";
    en_i = 1'b1;
    step(2 * NPIX + 3);
    scen = "R6 offset change mid-frame";
    offset_i = AW'(10);
    step(NPIX);
    scen = "R8 enable toggling";
    for (int i = 0; i < 12; i++) begin
      en_i = i[0];
      step(1 + (i % 3));
    end
    en_i = 1'b1;
    scen = "R5 offset zero clamps to one";
    offset_i = '0;
    step(2 * NPIX);
    scen = "R5 offset above range clamps";
    offset_i = AW'(31);
    step(2 * NPIX);
    scen = "R7 re-reset with max offset";
    rst_ni = 1'b0;
    offset_i = AW'(NPIX - 1);
    step(3);
    rst_ni = 1'b1;
    step(2 * NPIX + 2);
    scen = "R6 live offset before first advance";
    rst_ni = 1'b0;
    en_i = 1'b0;
    step(2);
    rst_ni = 1'b1;
    offset_i = AW'(3);
    step(2);
    offset_i = AW'(7);
    step(1);
    en_i = 1'b1;
    step(1);
    offset_i = AW'(2);
    step(NPIX + 4);
    finish_run();
  end
endmodule